// File: doc/BRIEF.md
# Microcontroller File Register Bank with Mapped I/O Ports

This block is the data-memory side of a small 8-bit microcontroller core. A 5-bit file address selects one of three I/O ports (A, B and C) or one of 24 general-purpose registers. The core has one synchronous write port and one combinational read port into this map. Each port also has a direction register. These direction registers sit outside the address map and are loaded only through a separate direction-load path, which the core drives when it executes a port-direction instruction.

Each port pin is modelled as three separate signals: a pin input, a driven output value and an output enable. The block registers the pin inputs on every clock edge. A read of a port returns a merge of two sources, chosen bit by bit by the direction register: the registered pin sample for input bits and the output latch for output bits. The general-purpose storage behaves like LUT-based distributed RAM. It is written on the clock edge, read without a clock, and not cleared by reset.

Top module: `mcu_filebank`

## Requirements
- R1: The file map places port A at address 0x05, port B at 0x06, port C at 0x07 and general-purpose registers at 0x08 to 0x1F. A value written to an output-configured port or to a general-purpose register reads back from the same address after the write edge.
- R2: Reading any address from 0x00 to 0x04 returns 0x00. A write to those addresses changes no port latch, no direction register and no general-purpose register.
- R3: Output enables are active high and are the inverse of the direction bits: a direction bit of 1 makes the pin an input (enable 0), and a direction bit of 0 makes it an output (enable 1).
- R4: Direction registers change only when `dir_we` is asserted. `dir_sel` value 0 selects A (low 4 bits of `dir_wdata`), 1 selects B and 2 selects C. Value 3 writes nothing. File writes to 0x05 to 0x07 never alter direction.
- R5: A port read returns, for each input bit, the pin value registered at the most recent clock edge, and for each output bit the output latch. A pin change becomes visible only after the next clock edge.
- R6: A file write to a port always loads its output latch, including bits currently set as inputs. The latch is driven on the port's output pins.
- R7: Reset sets every direction bit to 1, so all output enables are 0. It also clears the output latches and the pin samples. General-purpose registers are not cleared.
- R8: The read data follows `rd_addr` combinationally within a cycle. A general-purpose write becomes visible only after the clock edge that performs it.
- R9: Port A is 4 bits wide, and reading address 0x05 returns 0 in bits 7 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | File write strobe |
| wr_addr | input | 5 | File write address |
| wr_data | input | 8 | File write data |
| rd_addr | input | 5 | File read address |
| rd_data | output | 8 | Combinational file read data |
| dir_we | input | 1 | Direction-load strobe |
| dir_sel | input | 2 | Direction target: 0 A, 1 B, 2 C, 3 none |
| dir_wdata | input | 8 | Direction value, 1 = input |
| pa_in | input | 4 | Port A pin inputs |
| pa_out | output | 4 | Port A output latch |
| pa_oe | output | 4 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The hardest case to reach from the ports is a port read with mixed direction bits, where every bit must come from the correct source and pin changes must appear exactly one edge late. The stimulus first loads a split direction value through the direction path and writes a latch pattern that overlaps both halves. It then moves the pins at a falling edge. The read is checked once before the next rising edge, where only the old sample may show, and once after it. A second case loads the latch while the bits are inputs, then turns them to outputs, so the latch value must appear without any new file write.

// File: rtl/mcu_filebank_pkg.sv
package mcu_filebank_pkg;
    localparam int unsigned FB_ADDR_W   = 5;
    localparam int unsigned FB_DATA_W   = 8;
    localparam logic [4:0]  FB_ADR_PA   = 5'h05;
    localparam logic [4:0]  FB_ADR_PB   = 5'h06;
    localparam logic [4:0]  FB_ADR_PC   = 5'h07;
    localparam logic [4:0]  FB_ADR_GPR0 = 5'h08;

    typedef enum logic [1:0] {
        DSEL_A    = 2'd0,
        DSEL_B    = 2'd1,
        DSEL_C    = 2'd2,
        DSEL_NONE = 2'd3
    } dir_sel_e;
endpackage

// File: rtl/fb_port.sv
module fb_port #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lat_we,
    input  logic [W-1:0] lat_wdata,
    input  logic         dir_we,
    input  logic [W-1:0] dir_wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_val
);
    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] dir;
        logic [W-1:0] smp;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.smp = pin_in;
        if (lat_we) st_d.lat = lat_wdata;
        if (dir_we) st_d.dir = dir_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat <= '0;
            st_q.dir <= '1;
            st_q.smp <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out = st_q.lat;
    assign pin_oe  = ~st_q.dir;
    assign rd_val  = (st_q.dir & st_q.smp) | (~st_q.dir & st_q.lat);

    AST_DIR_LOAD:  assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |=> pin_oe == ~$past(dir_wdata));                    // R3
    AST_DIR_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
        !dir_we |=> $stable(pin_oe));                               // R4
    AST_LAT_LOAD:  assert property (@(posedge clk) disable iff (!rst_n)
        lat_we |=> pin_out == $past(lat_wdata));                    // R6
    AST_LAT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
        !lat_we |=> $stable(pin_out));                              // R6
    AST_PIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_we && !dir_we && $past(!dir_we)) |=>
            ((rd_val ^ $past(pin_in)) & ~pin_oe) == '0);            // R5
endmodule

// File: rtl/fb_gpr_ram.sv
module fb_gpr_ram #(
    parameter int unsigned DEPTH = 24,
    parameter int unsigned W     = 8,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we && (32'(widx) < DEPTH)) mem_d[widx] = wdata;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = (32'(ridx) < DEPTH) ? mem_q[ridx] : '0;

    AST_GPR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !$isunknown(widx)) |=> mem_q[$past(widx)] == $past(wdata)); // R8
endmodule

// File: rtl/mcu_filebank.sv
module mcu_filebank
    import mcu_filebank_pkg::*;
#(
    parameter int unsigned PA_W = 4,
    parameter int unsigned PB_W = 8,
    parameter int unsigned PC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [FB_ADDR_W-1:0] wr_addr,
    input  logic [FB_DATA_W-1:0] wr_data,
    input  logic [FB_ADDR_W-1:0] rd_addr,
    output logic [FB_DATA_W-1:0] rd_data,
    input  logic                 dir_we,
    input  logic [1:0]           dir_sel,
    input  logic [FB_DATA_W-1:0] dir_wdata,
    input  logic [PA_W-1:0]      pa_in,
    output logic [PA_W-1:0]      pa_out,
    output logic [PA_W-1:0]      pa_oe,
    input  logic [PB_W-1:0]      pb_in,
    output logic [PB_W-1:0]      pb_out,
    output logic [PB_W-1:0]      pb_oe,
    input  logic [PC_W-1:0]      pc_in,
    output logic [PC_W-1:0]      pc_out,
    output logic [PC_W-1:0]      pc_oe
);
    localparam int unsigned GPR_DEPTH = (1 << FB_ADDR_W) - int'(FB_ADR_GPR0);
    localparam int unsigned GIW       = $clog2(GPR_DEPTH);

    typedef struct packed {
        logic           we_a, we_b, we_c, we_g;
        logic           dw_a, dw_b, dw_c;
        logic [GIW-1:0] widx;
        logic [GIW-1:0] ridx;
    } dec_t;

    dec_t dec;
    logic [PA_W-1:0]      rv_a;
    logic [PB_W-1:0]      rv_b;
    logic [PC_W-1:0]      rv_c;
    logic [FB_DATA_W-1:0] rv_g;

    always_comb begin
        dec      = '0;
        dec.we_a = wr_en && (wr_addr == FB_ADR_PA);
        dec.we_b = wr_en && (wr_addr == FB_ADR_PB);
        dec.we_c = wr_en && (wr_addr == FB_ADR_PC);
        dec.we_g = wr_en && (wr_addr >= FB_ADR_GPR0);
        dec.dw_a = dir_we && (dir_sel == DSEL_A);
        dec.dw_b = dir_we && (dir_sel == DSEL_B);
        dec.dw_c = dir_we && (dir_sel == DSEL_C);
        dec.widx = (wr_addr >= FB_ADR_GPR0) ? GIW'(wr_addr - FB_ADR_GPR0) : '0;
        dec.ridx = (rd_addr >= FB_ADR_GPR0) ? GIW'(rd_addr - FB_ADR_GPR0) : '0;
    end

    fb_port #(.W(PA_W)) u_pa (
        .clk(clk), .rst_n(rst_n),
        .lat_we(dec.we_a), .lat_wdata(wr_data[PA_W-1:0]),
        .dir_we(dec.dw_a), .dir_wdata(dir_wdata[PA_W-1:0]),
        .pin_in(pa_in), .pin_out(pa_out), .pin_oe(pa_oe), .rd_val(rv_a)
    );

    fb_port #(.W(PB_W)) u_pb (
        .clk(clk), .rst_n(rst_n),
        .lat_we(dec.we_b), .lat_wdata(wr_data[PB_W-1:0]),
        .dir_we(dec.dw_b), .dir_wdata(dir_wdata[PB_W-1:0]),
        .pin_in(pb_in), .pin_out(pb_out), .pin_oe(pb_oe), .rd_val(rv_b)
    );

    fb_port #(.W(PC_W)) u_pc (
        .clk(clk), .rst_n(rst_n),
        .lat_we(dec.we_c), .lat_wdata(wr_data[PC_W-1:0]),
        .dir_we(dec.dw_c), .dir_wdata(dir_wdata[PC_W-1:0]),
        .pin_in(pc_in), .pin_out(pc_out), .pin_oe(pc_oe), .rd_val(rv_c)
    );

    fb_gpr_ram #(.DEPTH(GPR_DEPTH), .W(FB_DATA_W)) u_gpr (
        .clk(clk), .rst_n(rst_n),
        .we(dec.we_g), .widx(dec.widx), .wdata(wr_data),
        .ridx(dec.ridx), .rdata(rv_g)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == FB_ADR_PA)       rd_data = FB_DATA_W'(rv_a);
        else if (rd_addr == FB_ADR_PB)  rd_data = FB_DATA_W'(rv_b);
        else if (rd_addr == FB_ADR_PC)  rd_data = FB_DATA_W'(rv_c);
        else if (rd_addr >= FB_ADR_GPR0) rd_data = rv_g;
    end

    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr < FB_ADR_PA) |-> rd_data == '0);                   // R2
    AST_PA_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == FB_ADR_PA) |-> rd_data[FB_DATA_W-1:PA_W] == '0); // R9
    AST_LOW_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr < FB_ADR_PA && !dir_we) |=>
            ($stable(pa_out) && $stable(pb_out) && $stable(pc_out))); // R2
endmodule

// File: tb/sim_mcu_filebank.sv
module sim_mcu_filebank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       dir_we = 1'b0;
    logic [1:0] dir_sel = '0;
    logic [7:0] dir_wdata = '0;
    logic [3:0] pa_in = '0, pa_out, pa_oe;
    logic [7:0] pb_in = '0, pb_out, pb_oe;
    logic [7:0] pc_in = '0, pc_out, pc_oe;

    int n_run = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mcu_filebank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dir_we(dir_we), .dir_sel(dir_sel), .dir_wdata(dir_wdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // {address, write value, expected read}, all ports set to outputs
    localparam logic [20:0] VEC [8] = '{
        {5'h05, 8'hA7, 8'h07}, {5'h06, 8'h5A, 8'h5A},
        {5'h07, 8'hC3, 8'hC3}, {5'h08, 8'h11, 8'h11},
        {5'h1F, 8'hFE, 8'hFE}, {5'h12, 8'h80, 8'h80},
        {5'h06, 8'h00, 8'h00}, {5'h09, 8'h01, 8'h01}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic fwrite(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic dwrite(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        dir_we = 1'b1; dir_sel = s; dir_wdata = d;
        @(negedge clk);
        dir_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        rd_addr = a;
        #0.5;
        v = rd_data;
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] g8;
        pb_in = 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk("R7 pa_oe", {4'h0, pa_oe}, 8'h00);
        chk("R7 pb_oe", pb_oe, 8'h00);
        chk("R7 pc_oe", pc_oe, 8'h00);
        chk("R7 pb_out", pb_out, 8'h00);
        // R5 inputs after reset read pins
        rd(5'h06, v); chk("R5 pin read", v, 8'h5A);
        pb_in = 8'h00;
        @(negedge clk);

        // R3/R4 direction loads
        dwrite(2'd0, 8'h00); chk("R3 pa_oe", {4'h0, pa_oe}, 8'h0F);
        dwrite(2'd1, 8'h00); chk("R3 pb_oe", pb_oe, 8'hFF);
        dwrite(2'd2, 8'h00); chk("R3 pc_oe", pc_oe, 8'hFF);

        // R1/R6/R9 vector table
        foreach (VEC[i]) begin
            fwrite(VEC[i][20:16], VEC[i][15:8]);
            rd(VEC[i][20:16], v);
            chk("R1 table", v, VEC[i][7:0]);
        end
        chk("R6 pc_out", pc_out, 8'hC3);

        // R8 combinational read and edge-timed write
        fwrite(5'h10, 8'h3C);
        fwrite(5'h11, 8'h22);
        rd(5'h10, v); chk("R8 comb read a", v, 8'h3C);
        rd(5'h11, v); chk("R8 comb read b", v, 8'h22);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'h11; wr_data = 8'h77;
        #0.5; chk("R8 before edge", rd_data, 8'h22);
        @(negedge clk);
        wr_en = 1'b0;
        #0.5; chk("R8 after edge", rd_data, 8'h77);

        // R2 unmapped region
        rd(5'h08, g8);
        for (int a = 0; a < 5; a++) begin
            fwrite(5'(a), 8'hFF);
            rd(5'(a), v); chk("R2 low read", v, 8'h00);
        end
        chk("R2 pa_out", {4'h0, pa_out}, 8'h07);
        chk("R2 pb_out", pb_out, 8'h00);
        chk("R2 pc_out", pc_out, 8'hC3);
        chk("R2 pb_oe", pb_oe, 8'hFF);
        rd(5'h08, v); chk("R2 gpr kept", v, g8);

        // R4 no-target select and file writes leave direction alone
        dwrite(2'd3, 8'hFF);
        chk("R4 sel3 a", {4'h0, pa_oe}, 8'h0F);
        chk("R4 sel3 b", pb_oe, 8'hFF);
        chk("R4 sel3 c", pc_oe, 8'hFF);
        fwrite(5'h06, 8'hFF);
        chk("R4 file write", pb_oe, 8'hFF);

        // R5 mixed direction on port B
        dwrite(2'd1, 8'hF0);
        chk("R3 mixed oe", pb_oe, 8'h0F);
        fwrite(5'h06, 8'h3C);
        pb_in = 8'hA5;
        @(negedge clk);
        rd(5'h06, v); chk("R5 mixed", v, 8'hAC);
        @(negedge clk);
        pb_in = 8'h5A;
        #0.5; chk("R5 before edge", rd_data, 8'hAC);
        @(negedge clk);
        #0.5; chk("R5 after edge", rd_data, 8'h5C);

        // R6 latch loads while input, appears when turned to output
        dwrite(2'd2, 8'hFF);
        pc_in = 8'h0F;
        fwrite(5'h07, 8'h99);
        chk("R6 latch as input", pc_out, 8'h99);
        chk("R6 oe off", pc_oe, 8'h00);
        rd(5'h07, v); chk("R6 reads pins", v, 8'h0F);
        dwrite(2'd2, 8'h00);
        rd(5'h07, v); chk("R6 latch shown", v, 8'h99);

        // R9 port A upper bits
        fwrite(5'h05, 8'hFF);
        rd(5'h05, v); chk("R9 narrow read", v, 8'h0F);
        chk("R9 pa_out", {4'h0, pa_out}, 8'h0F);

        // R7 reset again restores directions and latches
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R7 re-reset oe", pc_oe, 8'h00);
        chk("R7 re-reset out", pc_out, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule